// File: doc/BRIEF.md
# Sequential Offset Register Loader

This block holds the two thresholds that a FIFO's flag logic compares against: the almost-empty offset `n` and the almost-full offset `m`. Each offset lives in a pair of byte registers, one low and one high. Four registers are therefore reachable, and software reaches them without any address. An internal step pointer walks the four registers in a fixed order and wraps after the last one. A write-domain pointer takes bytes from the FIFO data input. A read-domain pointer presents the registers on a readback output. Both operate only while the active-low load strobe is held low.

The operating mode is chosen during reset from the level of the load strobe. If the strobe is low during reset, the block enters load mode and programming is possible. If the strobe is high during reset, the block enters two-enable mode. In that mode the pin serves elsewhere as a second write enable, and the offsets remain at their defaults.

Programming may be split across several bursts. Raising the strobe pauses the pointers in place. The next access under the strobe continues at the register that follows the last one accessed.

Top module: `offset_seq_loader`

## Requirements
- R1: While `rstN` is low at a clock edge, both offsets take the value 7, `rdbkData` becomes 0, `rdbkStrobe` becomes 0, and both step pointers return to step 0.
- R2: In load mode, a `wrClk` edge with `loadN`=0 and `wrEn1N`=0 stores `dataIn[7:0]` into the register at the write pointer, and the pointer then advances. The step order is 0 = empty low, 1 = empty high, 2 = full low, 3 = full high.
- R3: The step after step 3 is step 0, so a fifth consecutive write lands in the empty-low register again.
- R4: A `wrClk` edge with `loadN`=1 changes neither offset nor the write pointer, so the next load write continues at the following step.
- R5: A `wrClk` edge with `wrEn1N`=1 changes neither offset nor the write pointer.
- R6: In load mode, an `rdClk` edge with `loadN`=0, `rdEn1N`=0 and `rdEn2N`=0 loads the register at the read pointer into `rdbkData`, zero-extended to `DATA_W` bits, and sets `rdbkStrobe` for one cycle. The read pointer then advances with the same order and wrap as R2 and R3.
- R7: An `rdClk` edge where `rdEn1N`, `rdEn2N` or `loadN` is 1 leaves `rdbkData` unchanged and clears `rdbkStrobe`.
- R8: `emptyOff` is formed as {empty-high[ADDR_W-9:0], empty-low}, and `fullOff` is formed the same way from the full registers. High-register bits above `ADDR_W-9` are discarded on write and read back as 0. Bit 8 of `rdbkData` is always 0.
- R9: If `loadN` is 1 during reset, the block enters two-enable mode. In that mode no offset write or readback ever happens, and the offsets remain 7.
- R10: A write access and a read access in the same cycle act independently. Each uses its own pointer, and the readback returns the register contents as they were before that edge's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Active-low synchronous reset, seen by both domains |
| loadN | input | 1 | Active-low load strobe; its level during reset picks the mode |
| wrEn1N | input | 1 | Active-low write enable |
| rdEn1N | input | 1 | Active-low read enable, first of two |
| rdEn2N | input | 1 | Active-low read enable, second of two |
| dataIn | input | DATA_W | FIFO data input; the low byte is the programming value |
| emptyOff | output | ADDR_W | Assembled almost-empty offset n |
| fullOff | output | ADDR_W | Assembled almost-full offset m |
| rdbkData | output | DATA_W | Readback word for the FIFO output path |
| rdbkStrobe | output | 1 | High for one cycle after a readback access |

## Verification
The two functions that can fall in the same cycle are an offset write and an offset readback. The bench provokes this by holding the load strobe, the write enable and both read enables low together at one edge, with the two pointers parked at different steps.

The behavioural model decides the result. The readback must carry the register's old contents, and the offset must take the new byte. A further read at that step must then return the new byte.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  localparam int BYTE_W = 8;
  localparam int NUM_STEPS = 4;

  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofsSel_e;

  typedef struct packed {
    logic    wrStb;
    ofsSel_e wrSel;
    logic    rdStb;
    ofsSel_e rdSel;
  } ofsCtl_t;

  function automatic ofsSel_e nextSel(input ofsSel_e cur);
    return ofsSel_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
(
  input  logic    wrClk,
  input  logic    rdClk,
  input  logic    rstN,
  input  logic    loadN,
  input  logic    wrEn1N,
  input  logic    rdEn1N,
  input  logic    rdEn2N,
  output ofsCtl_t ctl
);

  // Write domain: mode capture and step pointer
  logic    wrTwoEn;
  ofsSel_e wrPtr;
  logic    wrHit;

  assign wrHit = !wrTwoEn && !loadN && !wrEn1N;

  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      wrTwoEn <= loadN;
      wrPtr   <= SEL_EMPTY_LO;
    end else if (wrHit) begin
      wrPtr <= nextSel(wrPtr);
    end
  end

  // Read domain: own copy of the mode and its own step pointer
  logic    rdTwoEn;
  ofsSel_e rdPtr;
  logic    rdHit;

  assign rdHit = !rdTwoEn && !loadN && !rdEn1N && !rdEn2N;

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      rdTwoEn <= loadN;
      rdPtr   <= SEL_EMPTY_LO;
    end else if (rdHit) begin
      rdPtr <= nextSel(rdPtr);
    end
  end

  always_comb begin
    ctl.wrStb = wrHit;
    ctl.wrSel = wrPtr;
    ctl.rdStb = rdHit;
    ctl.rdSel = rdPtr;
  end

endmodule

// File: rtl/ofs_datapath.sv
module ofs_datapath
  import ofs_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 11,
  parameter int DEFAULT_OFS = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  ofsCtl_t           ctl,
  output logic [ADDR_W-1:0] emptyOff,
  output logic [ADDR_W-1:0] fullOff,
  output logic [DATA_W-1:0] rdbkData,
  output logic              rdbkStrobe
);

  localparam int HI_W = ADDR_W - BYTE_W;
  localparam logic [ADDR_W-1:0] DEF_OFS = ADDR_W'(DEFAULT_OFS);

  logic [BYTE_W-1:0] loView [2];
  logic [BYTE_W-1:0] hiView [2];
  logic [ADDR_W-1:0] ofsVal [2];

  // One register pair per offset: index 0 = empty, 1 = full
  for (genvar g = 0; g < 2; g++) begin : g_ofs
    localparam ofsSel_e LO_SEL = ofsSel_e'(2'(2 * g));
    localparam ofsSel_e HI_SEL = ofsSel_e'(2'(2 * g + 1));

    logic [BYTE_W-1:0] loReg;

    always_ff @(posedge wrClk) begin
      if (!rstN) begin
        loReg <= DEF_OFS[BYTE_W-1:0];
      end else if (ctl.wrStb && ctl.wrSel == LO_SEL) begin
        loReg <= dataIn[BYTE_W-1:0];
      end
    end

    assign loView[g] = loReg;

    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hiReg;

      always_ff @(posedge wrClk) begin
        if (!rstN) begin
          hiReg <= DEF_OFS[ADDR_W-1:BYTE_W];
        end else if (ctl.wrStb && ctl.wrSel == HI_SEL) begin
          hiReg <= dataIn[HI_W-1:0];
        end
      end

      assign hiView[g] = BYTE_W'(hiReg);
      assign ofsVal[g] = {hiReg, loReg};
    end else begin : g_nohi
      assign hiView[g] = '0;
      assign ofsVal[g] = ADDR_W'(loReg);
    end
  end

  if (DATA_W > BYTE_W) begin : g_spare
    logic unusedUpperData;
    assign unusedUpperData = ^dataIn[DATA_W-1:BYTE_W];
  end

  assign emptyOff = ofsVal[0];
  assign fullOff  = ofsVal[1];

  // Readback selection and output register (read domain)
  logic [BYTE_W-1:0] rdByte;
  logic [DATA_W-1:0] rdWord;

  always_comb begin
    unique case (ctl.rdSel)
      SEL_EMPTY_LO: rdByte = loView[0];
      SEL_EMPTY_HI: rdByte = hiView[0];
      SEL_FULL_LO:  rdByte = loView[1];
      default:      rdByte = hiView[1];
    endcase
    rdWord = '0;
    rdWord[BYTE_W-1:0] = rdByte;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      rdbkData   <= '0;
      rdbkStrobe <= 1'b0;
    end else begin
      rdbkStrobe <= ctl.rdStb;
      if (ctl.rdStb) begin
        rdbkData <= rdWord;
      end
    end
  end

endmodule

// File: rtl/offset_seq_loader.sv
module offset_seq_loader
  import ofs_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 2048,
  parameter int DEFAULT_OFS = 7,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              wrEn1N,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] emptyOff,
  output logic [ADDR_W-1:0] fullOff,
  output logic [DATA_W-1:0] rdbkData,
  output logic              rdbkStrobe
);

  ofsCtl_t ctl;

  ofs_ctrl uCtrl (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .loadN (loadN),
    .wrEn1N(wrEn1N),
    .rdEn1N(rdEn1N),
    .rdEn2N(rdEn2N),
    .ctl   (ctl)
  );

  ofs_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .DEFAULT_OFS(DEFAULT_OFS)
  ) uData (
    .wrClk     (wrClk),
    .rdClk     (rdClk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .ctl       (ctl),
    .emptyOff  (emptyOff),
    .fullOff   (fullOff),
    .rdbkData  (rdbkData),
    .rdbkStrobe(rdbkStrobe)
  );

endmodule

// File: rtl/offset_seq_loader_chk.sv
module offset_seq_loader_chk #(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 11,
  parameter int DEFAULT_OFS = 7
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              loadN,
  input logic              wrEn1N,
  input logic              rdEn1N,
  input logic              rdEn2N,
  input logic [ADDR_W-1:0] emptyOff,
  input logic [ADDR_W-1:0] fullOff,
  input logic [DATA_W-1:0] rdbkData,
  input logic              rdbkStrobe
);

  localparam logic [ADDR_W-1:0] DEF_OFS = ADDR_W'(DEFAULT_OFS);

  // R1: defaults are in place on the first edge after reset
  assert_reset_defaults_R1: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(rstN) |-> (emptyOff == DEF_OFS && fullOff == DEF_OFS));

  assert_reset_readback_R1: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(rstN) |-> (rdbkData == '0 && !rdbkStrobe));

  // R4: load strobe high leaves the offsets alone
  assert_hold_load_high_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    loadN |=> ($stable(emptyOff) && $stable(fullOff)));

  // R5: write enable high leaves the offsets alone
  assert_hold_no_enable_R5: assert property (@(posedge wrClk) disable iff (!rstN)
    wrEn1N |=> ($stable(emptyOff) && $stable(fullOff)));

  // R7: readback gated by strobe and both enables
  assert_read_gated_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    (loadN || rdEn1N || rdEn2N) |=> (!rdbkStrobe && $stable(rdbkData)));

  // R8: readback never carries bits above the byte
  assert_upper_bits_zero_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    rdbkStrobe |-> ((rdbkData >> 8) == '0));

endmodule

bind offset_seq_loader offset_seq_loader_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .DEFAULT_OFS(DEFAULT_OFS)
) uChk (
  .wrClk     (wrClk),
  .rdClk     (rdClk),
  .rstN      (rstN),
  .loadN     (loadN),
  .wrEn1N    (wrEn1N),
  .rdEn1N    (rdEn1N),
  .rdEn2N    (rdEn2N),
  .emptyOff  (emptyOff),
  .fullOff   (fullOff),
  .rdbkData  (rdbkData),
  .rdbkStrobe(rdbkStrobe)
);

// File: tb/tb_offset_seq_loader.sv
`timescale 1ns/1ps
module tb_offset_seq_loader;

  localparam int DATA_W = 9;
  localparam int DEPTH  = 2048;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int HI_MASK = (1 << (ADDR_W - 8)) - 1;

  logic clk = 1'b0;
  logic rstN, loadN, wrEn1N, rdEn1N, rdEn2N;
  logic [DATA_W-1:0] dataIn;
  logic [ADDR_W-1:0] emptyOff, fullOff;
  logic [DATA_W-1:0] rdbkData;
  logic rdbkStrobe;

  always #2.5 clk = ~clk;

  offset_seq_loader #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DEFAULT_OFS(7)) dut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .loadN(loadN), .wrEn1N(wrEn1N),
    .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .dataIn(dataIn), .emptyOff(emptyOff),
    .fullOff(fullOff), .rdbkData(rdbkData), .rdbkStrobe(rdbkStrobe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmpOn = 0;
  string curReq = "R1";

  // Behavioural reference model
  int mReg [4];
  int wp, rp;
  bit mTwo;
  int mRd;
  bit mStb;

  always @(posedge clk) begin
    if (!rstN) begin
      mReg[0] = 7; mReg[1] = 0; mReg[2] = 7; mReg[3] = 0;
      wp = 0; rp = 0; mTwo = loadN; mRd = 0; mStb = 0;
    end else begin
      if (!mTwo && !loadN && !rdEn1N && !rdEn2N) begin
        mRd = mReg[rp];
        rp = (rp + 1) % 4;
        mStb = 1;
      end else begin
        mStb = 0;
      end
      if (!mTwo && !loadN && !wrEn1N) begin
        mReg[wp] = (wp % 2 == 1) ? (int'(dataIn) & HI_MASK) : (int'(dataIn) & 255);
        wp = (wp + 1) % 4;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare against the model away from the active edge
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      chk(curReq, "emptyOff", 32'(emptyOff), 32'(mReg[0] + mReg[1] * 256));
      chk(curReq, "fullOff", 32'(fullOff), 32'(mReg[2] + mReg[3] * 256));
      chk(curReq, "rdbkData", 32'(rdbkData), 32'(mRd));
      chk(curReq, "rdbkStrobe", 32'(rdbkStrobe), 32'(mStb));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    loadN = 1'b0; wrEn1N = 1'b1; rdEn1N = 1'b1; rdEn2N = 1'b1;
  endtask

  task automatic wr(input logic [DATA_W-1:0] d);
    loadN = 1'b0; wrEn1N = 1'b0; rdEn1N = 1'b1; rdEn2N = 1'b1; dataIn = d;
    cyc();
    wrEn1N = 1'b1;
  endtask

  task automatic rd(input int exp);
    loadN = 1'b0; wrEn1N = 1'b1; rdEn1N = 1'b0; rdEn2N = 1'b0;
    cyc();
    rdEn1N = 1'b1; rdEn2N = 1'b1;
    chk("R6", "readback value", 32'(rdbkData), 32'(exp));
    chk("R6", "readback strobe", 32'(rdbkStrobe), 32'd1);
  endtask

  task automatic doReset(input logic modeLevel);
    rstN = 1'b0; loadN = modeLevel; wrEn1N = 1'b1; rdEn1N = 1'b1; rdEn2N = 1'b1;
    dataIn = '0;
    repeat (3) cyc();
    rstN = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset defaults in load mode
    curReq = "R1";
    doReset(1'b0);
    idle();
    chk("R1", "emptyOff", 32'(emptyOff), 32'd7);
    chk("R1", "fullOff", 32'(fullOff), 32'd7);
    chk("R1", "rdbkData", 32'(rdbkData), 32'd0);
    chk("R1", "rdbkStrobe", 32'(rdbkStrobe), 32'd0);
    cmpOn = 1;
    cyc();

    // R2: four writes in step order
    curReq = "R2";
    wr(9'h1A5);
    chk("R2", "empty low first", 32'(emptyOff), 32'h0A5);
    wr(9'h0FE);
    wr(9'h033);
    wr(9'h1FD);
    chk("R2", "emptyOff", 32'(emptyOff), 32'h6A5);
    chk("R2", "fullOff", 32'(fullOff), 32'h533);
    // R8: high byte truncated to the offset width
    chk("R8", "empty high truncated", 32'(emptyOff >> 8), 32'h6);

    // R3: fifth write wraps to empty low
    curReq = "R3";
    wr(9'h111);
    chk("R3", "wrap to empty low", 32'(emptyOff), 32'h611);

    // R4: load high pauses, then programming resumes at the next step
    curReq = "R4";
    loadN = 1'b1; wrEn1N = 1'b0;
    for (int i = 0; i < 3; i++) begin
      dataIn = 9'(8'h40 + i);
      cyc();
    end
    chk("R4", "no write with load high", 32'(emptyOff), 32'h611);
    wr(9'h002);
    chk("R4", "resume at empty high", 32'(emptyOff), 32'h211);
    chk("R4", "full untouched", 32'(fullOff), 32'h533);

    // R5: enable high under load strobe
    curReq = "R5";
    idle();
    dataIn = 9'h0FF;
    repeat (2) cyc();
    chk("R5", "emptyOff held", 32'(emptyOff), 32'h211);
    chk("R5", "fullOff held", 32'(fullOff), 32'h533);

    // R6: readback in step order with wrap
    curReq = "R6";
    rd(32'h11);
    rd(32'h02);
    rd(32'h33);
    rd(32'h05);
    rd(32'h11);
    chk("R8", "upper readback bit", 32'(rdbkData[8]), 32'd0);

    // R7: any enable high, or load high, blocks readback
    curReq = "R7";
    loadN = 1'b0; rdEn1N = 1'b1; rdEn2N = 1'b0; cyc();
    chk("R7", "strobe with rdEn1N high", 32'(rdbkStrobe), 32'd0);
    rdEn1N = 1'b0; rdEn2N = 1'b1; cyc();
    chk("R7", "strobe with rdEn2N high", 32'(rdbkStrobe), 32'd0);
    loadN = 1'b1; rdEn1N = 1'b0; rdEn2N = 1'b0; cyc();
    chk("R7", "strobe with load high", 32'(rdbkStrobe), 32'd0);
    chk("R7", "data held", 32'(rdbkData), 32'h11);

    // R10: write and read in the same edge
    curReq = "R10";
    loadN = 1'b0; wrEn1N = 1'b0; rdEn1N = 1'b0; rdEn2N = 1'b0; dataIn = 9'h0C4;
    cyc();
    idle();
    chk("R10", "read sees old empty high", 32'(rdbkData), 32'h002);
    chk("R10", "write landed in full low", 32'(fullOff), 32'h5C4);
    rd(32'hC4);

    // R9: two-enable mode keeps defaults
    curReq = "R9";
    cmpOn = 0;
    doReset(1'b1);
    cmpOn = 1;
    loadN = 1'b0; wrEn1N = 1'b0; rdEn1N = 1'b0; rdEn2N = 1'b0; dataIn = 9'h0AA;
    repeat (2) cyc();
    loadN = 1'b1;
    repeat (2) cyc();
    chk("R9", "emptyOff default", 32'(emptyOff), 32'd7);
    chk("R9", "fullOff default", 32'(fullOff), 32'd7);
    chk("R9", "no readback", 32'(rdbkStrobe), 32'd0);
    chk("R9", "readback data", 32'(rdbkData), 32'd0);

    // R1: back to load mode, pointer starts at empty low
    curReq = "R1";
    cmpOn = 0;
    doReset(1'b0);
    cmpOn = 1;
    idle();
    cyc();
    wr(9'h0AB);
    chk("R1", "pointer restarted", 32'(emptyOff), 32'h0AB);
    chk("R1", "full default", 32'(fullOff), 32'd7);
    cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule